// File: doc/BRIEF.md
# Shared-Coefficient I/Q Decimating FIR

This block is the last filtering stage of a complex receive path. Signed 23-bit I and Q samples arrive on a valid-qualified stream and are kept in two sample histories. A single coefficient memory holds up to 48 signed 20-bit taps. When the decimation counter wraps, the block freezes a copy of both histories and runs a multiply-accumulate sequence. On each clock of that sequence it adds one I product and one Q product, and both products use the same coefficient. The result is rounded and saturated to a 24-bit or a 16-bit output and is presented as a one-cycle pulse.

Software sets the filter up through a byte-wide register port and a separate coefficient write port. The registers hold the number of taps, the decimation factor, a counter preload that shifts where outputs fall in the input stream, and the output format. Writes through either port are accepted only while no sequence is running.

Top module: `iq_decim_fir`

## Requirements
- R1: After reset, out_valid and overflow are low and out_i/out_q are zero. The defaults are one tap, decimation by one, all coefficients zero, 24-bit output and a counter value of zero.
- R2: Each output equals the sum over k = 0..N-1 of coef[k] times x[k], computed separately for I and for Q with the same coef[k]. Here x[0] is the sample that triggered the output and x[k] is the sample accepted k inputs earlier.
- R3: Register 0x1A takes N-1 in bits [5:0], and any written value above 47 selects 48 taps. The output pulse appears on the clock edge N+1 cycles after the edge that accepted the triggering sample, and busy falls one cycle before it.
- R4: Register 0x18 bits [2:0] take M-1 for a decimation factor M of 1 to 8. The counter advances on each accepted sample and restarts at zero after reaching M-1, and the sample that hits M-1 triggers an output. out_valid never stays high for two cycles in a row.
- R5: A write to register 0x19 loads bits [2:0] straight into the decimation counter. A sample accepted on that same cycle is stored but does not advance the counter or trigger. A loaded value above M-1 counts up through 7 and wraps to 0 before it can match.
- R6: In 24-bit mode the result is acc / 2^19, rounded half-up (add 2^18, then arithmetic shift), and saturated to the range -8388608..8388607.
- R7: Register 0x1B bit 0 set to 1 selects 16-bit mode. The result is then acc / 2^27, rounded half-up and saturated to -32768..32767, and is sign-extended on the 24-bit output.
- R8: A trigger that arrives while a sequence is running is dropped. It produces a one-cycle overflow pulse one edge later, and the counter still advances.
- R9: Register and coefficient writes made while a sequence is running have no effect. Coefficient writes to addresses 48 and above are ignored.
- R10: The accumulator keeps full precision (49 bits by default), so large partial sums that cancel never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register address |
| cfg_wdata | input | 8 | Register write data |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 6 | Coefficient index |
| coef_wdata | input | 20 | Signed coefficient |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 23 | Signed I sample |
| in_q | input | 23 | Signed Q sample |
| out_valid | output | 1 | Result pulse |
| out_i | output | 24 | Signed I result |
| out_q | output | 24 | Signed Q result |
| overflow | output | 1 | Dropped-trigger pulse |

## Verification
An impulse on I paired with a different value on Q shows that both lanes use the same coefficient and that the taps appear in time order. Random data against random coefficients exercises the tap ordering and the rounding. Full-scale samples against full-scale coefficients of one sign drive both output formats into positive and negative saturation. Alternating coefficient signs build partial sums that would wrap a narrow accumulator. A continuous input stream at decimation by one, with more taps than the spacing between triggers, separates overflow reporting from normal output, and writes issued during a sequence show up as changed later results if they were wrongly accepted.

// File: rtl/iqf_pkg.sv
`timescale 1ns/1ps
package iqf_pkg;
   localparam logic [7:0] REG_DECIM = 8'h18;
   localparam logic [7:0] REG_PHASE = 8'h19;
   localparam logic [7:0] REG_TAPS  = 8'h1A;
   localparam logic [7:0] REG_FMT   = 8'h1B;

   typedef enum logic [0:0] {
      FMT_WIDE   = 1'b0,
      FMT_NARROW = 1'b1
   } out_fmt_e;
endpackage

// File: rtl/iqf_ctrl.sv
`timescale 1ns/1ps
module iqf_ctrl
   import iqf_pkg::*;
#(
   parameter  int MAX_TAPS = 48,
   parameter  int CNT_W    = 3,
   localparam int TAP_AW   = $clog2(MAX_TAPS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [7:0]        cfg_addr,
   input  logic [7:0]        cfg_wdata,
   input  logic              in_valid,
   output logic              busy,
   output logic              start,
   output logic              done,
   output logic              ovf,
   output logic [TAP_AW-1:0] tap_idx,
   output out_fmt_e          fmt
);
   localparam logic [TAP_AW-1:0] TAP_LIM = TAP_AW'(MAX_TAPS - 1);

   logic [CNT_W-1:0]  dec_m1, cnt;
   logic [TAP_AW-1:0] taps_m1, taps_req;
   logic              cfg_ok, phase_ld, wrap, last;

   always_comb begin
      cfg_ok   = cfg_we && !busy;
      phase_ld = cfg_ok && (cfg_addr == REG_PHASE);
      wrap     = in_valid && !phase_ld && (cnt == dec_m1);
      start    = wrap && !busy;
      last     = busy && (tap_idx == taps_m1);
      taps_req = (cfg_wdata > 8'(MAX_TAPS - 1)) ? TAP_LIM : cfg_wdata[TAP_AW-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_m1  <= '0;
         taps_m1 <= '0;
         fmt     <= FMT_WIDE;
      end else if (cfg_ok) begin
         case (cfg_addr)
            REG_DECIM: dec_m1  <= cfg_wdata[CNT_W-1:0];
            REG_TAPS:  taps_m1 <= taps_req;
            REG_FMT:   fmt     <= out_fmt_e'(cfg_wdata[0]);
            default:   ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        cnt <= '0;
      else if (phase_ld) cnt <= cfg_wdata[CNT_W-1:0];
      else if (in_valid) cnt <= (cnt == dec_m1) ? '0 : cnt + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         tap_idx <= '0;
         ovf     <= 1'b0;
         done    <= 1'b0;
      end else begin
         ovf  <= wrap && busy;
         done <= last;
         if (start) begin
            busy    <= 1'b1;
            tap_idx <= '0;
         end else if (busy) begin
            if (last) busy    <= 1'b0;
            else      tap_idx <= tap_idx + 1'b1;
         end
      end
   end

   // R9
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy) |-> ($stable(taps_m1) && $stable(dec_m1) && $stable(fmt)));

   // R8
   ovf_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |-> $past(busy));
endmodule

// File: rtl/iqf_hist.sv
`timescale 1ns/1ps
module iqf_hist #(
   parameter  int SAMP_W = 23,
   parameter  int DEPTH  = 48,
   localparam int AW     = $clog2(DEPTH)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     push,
   input  logic                     capture,
   input  logic signed [SAMP_W-1:0] in_i,
   input  logic signed [SAMP_W-1:0] in_q,
   input  logic [AW-1:0]            rd_idx,
   output logic signed [SAMP_W-1:0] rd_i,
   output logic signed [SAMP_W-1:0] rd_q
);
   logic signed [SAMP_W-1:0] hist_i [DEPTH-1];
   logic signed [SAMP_W-1:0] hist_q [DEPTH-1];
   logic signed [SAMP_W-1:0] snap_i [DEPTH];
   logic signed [SAMP_W-1:0] snap_q [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int j = 0; j < DEPTH - 1; j++) begin
            hist_i[j] <= '0;
            hist_q[j] <= '0;
         end
         for (int j = 0; j < DEPTH; j++) begin
            snap_i[j] <= '0;
            snap_q[j] <= '0;
         end
      end else begin
         if (push) begin
            hist_i[0] <= in_i;
            hist_q[0] <= in_q;
            for (int j = 1; j < DEPTH - 1; j++) begin
               hist_i[j] <= hist_i[j-1];
               hist_q[j] <= hist_q[j-1];
            end
         end
         if (capture) begin
            snap_i[0] <= in_i;
            snap_q[0] <= in_q;
            for (int j = 1; j < DEPTH; j++) begin
               snap_i[j] <= hist_i[j-1];
               snap_q[j] <= hist_q[j-1];
            end
         end
      end
   end

   assign rd_i = snap_i[rd_idx];
   assign rd_q = snap_q[rd_idx];
endmodule

// File: rtl/iqf_mac.sv
`timescale 1ns/1ps
module iqf_mac
   import iqf_pkg::*;
#(
   parameter int SAMP_W   = 23,
   parameter int COEF_W   = 20,
   parameter int ACC_W    = 49,
   parameter int OUT_W    = 24,
   parameter int NARROW_W = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clr,
   input  logic                        en,
   input  logic                        fin,
   input  out_fmt_e                    fmt,
   input  logic signed [COEF_W-1:0]    coef,
   input  logic [1:0][SAMP_W-1:0]      smp,
   output logic                        out_valid,
   output logic [1:0][OUT_W-1:0]       res
);
   localparam int PROD_W = SAMP_W + COEF_W;
   localparam int SH_W   = COEF_W - 1;
   localparam int SH_N   = SH_W + OUT_W - NARROW_W;
   localparam logic signed [ACC_W:0] HALF_W = (ACC_W+1)'(1) <<< (SH_W - 1);
   localparam logic signed [ACC_W:0] HALF_N = (ACC_W+1)'(1) <<< (SH_N - 1);
   localparam logic signed [ACC_W:0] HI_W   = (ACC_W+1)'(2**(OUT_W-1) - 1);
   localparam logic signed [ACC_W:0] LO_W   = (ACC_W+1)'(-(2**(OUT_W-1)));
   localparam logic signed [ACC_W:0] HI_N   = (ACC_W+1)'(2**(NARROW_W-1) - 1);
   localparam logic signed [ACC_W:0] LO_N   = (ACC_W+1)'(-(2**(NARROW_W-1)));

   always_ff @(posedge clk) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= fin;
   end

   for (genvar g = 0; g < 2; g++) begin : g_lane
      logic signed [PROD_W-1:0] prod;
      logic signed [ACC_W-1:0]  acc;
      logic signed [ACC_W:0]    rnd, shv, hi, lo;
      logic [OUT_W-1:0]         satv;

      assign prod = coef * $signed(smp[g]);

      always_ff @(posedge clk) begin
         if (!rst_n || clr) acc <= '0;
         else if (en)       acc <= acc + {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
      end

      always_comb begin
         if (fmt == FMT_NARROW) begin
            rnd = {acc[ACC_W-1], acc} + HALF_N;
            shv = rnd >>> SH_N;
            hi  = HI_N;
            lo  = LO_N;
         end else begin
            rnd = {acc[ACC_W-1], acc} + HALF_W;
            shv = rnd >>> SH_W;
            hi  = HI_W;
            lo  = LO_W;
         end
         if (shv > hi)      satv = hi[OUT_W-1:0];
         else if (shv < lo) satv = lo[OUT_W-1:0];
         else               satv = shv[OUT_W-1:0];
      end

      always_ff @(posedge clk) begin
         if (!rst_n)   res[g] <= '0;
         else if (fin) res[g] <= satv;
      end

      // R7
      narrow_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && $past(fmt) == FMT_NARROW) |->
            ($signed(res[g]) <= (2**(NARROW_W-1) - 1) && $signed(res[g]) >= -(2**(NARROW_W-1))));
   end
endmodule

// File: rtl/iq_decim_fir.sv
`timescale 1ns/1ps
module iq_decim_fir
   import iqf_pkg::*;
#(
   parameter  int SAMP_W   = 23,
   parameter  int COEF_W   = 20,
   parameter  int MAX_TAPS = 48,
   parameter  int DEC_W    = 3,
   parameter  int OUT_W    = 24,
   parameter  int NARROW_W = 16,
   localparam int TAP_AW   = $clog2(MAX_TAPS),
   localparam int ACC_W    = SAMP_W + COEF_W + TAP_AW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [7:0]        cfg_addr,
   input  logic [7:0]        cfg_wdata,
   input  logic              coef_we,
   input  logic [TAP_AW-1:0] coef_addr,
   input  logic [COEF_W-1:0] coef_wdata,
   input  logic              in_valid,
   input  logic [SAMP_W-1:0] in_i,
   input  logic [SAMP_W-1:0] in_q,
   output logic              out_valid,
   output logic [OUT_W-1:0]  out_i,
   output logic [OUT_W-1:0]  out_q,
   output logic              overflow
);
   if (MAX_TAPS < 2 || MAX_TAPS > 256) begin : g_bad_taps
      $error("iq_decim_fir: MAX_TAPS must lie in 2..256");
   end
   if (NARROW_W >= OUT_W) begin : g_bad_fmt
      $error("iq_decim_fir: NARROW_W must be below OUT_W");
   end
   if (DEC_W > 8) begin : g_bad_dec
      $error("iq_decim_fir: DEC_W must fit the register byte");
   end

   logic                     busy, start, done;
   logic [TAP_AW-1:0]        tap_idx;
   out_fmt_e                 fmt;
   logic signed [SAMP_W-1:0] rd_i, rd_q;
   logic signed [COEF_W-1:0] coef_mem [MAX_TAPS];
   logic [1:0][SAMP_W-1:0]   smp;
   logic [1:0][OUT_W-1:0]    res;

   iqf_ctrl #(.MAX_TAPS(MAX_TAPS), .CNT_W(DEC_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .in_valid(in_valid), .busy(busy), .start(start),
      .done(done), .ovf(overflow), .tap_idx(tap_idx), .fmt(fmt)
   );

   iqf_hist #(.SAMP_W(SAMP_W), .DEPTH(MAX_TAPS)) u_hist (
      .clk(clk), .rst_n(rst_n), .push(in_valid), .capture(start),
      .in_i(in_i), .in_q(in_q), .rd_idx(tap_idx), .rd_i(rd_i), .rd_q(rd_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < MAX_TAPS; k++) coef_mem[k] <= '0;
      end else if (coef_we && !busy && ({1'b0, coef_addr} < (TAP_AW+1)'(MAX_TAPS))) begin
         coef_mem[coef_addr] <= coef_wdata;
      end
   end

   assign smp = {rd_q, rd_i};

   iqf_mac #(.SAMP_W(SAMP_W), .COEF_W(COEF_W), .ACC_W(ACC_W),
             .OUT_W(OUT_W), .NARROW_W(NARROW_W)) u_mac (
      .clk(clk), .rst_n(rst_n), .clr(start), .en(busy), .fin(done), .fmt(fmt),
      .coef(coef_mem[tap_idx]), .smp(smp), .out_valid(out_valid), .res(res)
   );

   assign out_i = res[0];
   assign out_q = res[1];

   // R3
   done_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |=> out_valid);

   // R4
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);
endmodule

// File: tb/iq_decim_fir_tb_top.sv
`timescale 1ns/1ps
module iq_decim_fir_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we, coef_we, in_valid;
   logic [7:0]  cfg_addr, cfg_wdata;
   logic [5:0]  coef_addr;
   logic [19:0] coef_wdata;
   logic [22:0] in_i, in_q;
   logic        out_valid, overflow;
   logic [23:0] out_i, out_q;

   always #2 clk = ~clk;

   iq_decim_fir dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .coef_we(coef_we), .coef_addr(coef_addr),
      .coef_wdata(coef_wdata), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
      .out_valid(out_valid), .out_i(out_i), .out_q(out_q), .overflow(overflow)
   );

   int     n_chk = 0, n_err = 0, wd = 0;
   string  cur_req = "R1";

   longint m_h_i [48], m_h_q [48], m_c [48];
   int     m_dec, m_cnt, m_taps, m_pend;
   bit     m_n16, e_valid, e_ovf;
   longint r_i, r_q, e_i, e_q;

   function automatic longint rsat(longint a, bit n16);
      int     s   = n16 ? 27 : 19;
      longint lim = n16 ? 32767 : 8388607;
      longint r   = (a + (longint'(1) <<< (s - 1))) >>> s;
      if (r > lim)      return lim;
      if (r < -lim - 1) return -lim - 1;
      return r;
   endfunction

   function automatic longint rs23();
      return longint'($urandom_range(0, 8388607)) - 4194304;
   endfunction

   function automatic longint rc20();
      return longint'($urandom_range(0, 1048575)) - 524288;
   endfunction

   task automatic chk(string what, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int k = 0; k < 48; k++) begin
         m_h_i[k] = 0; m_h_q[k] = 0; m_c[k] = 0;
      end
      m_dec = 0; m_cnt = 0; m_taps = 1; m_pend = 0; m_n16 = 0;
   endtask

   task automatic model_step();
      bit     bz, pld, wrap;
      longint ai, aq;
      bz = (m_pend >= 2);
      e_valid = 0;
      e_ovf   = 0;
      if (m_pend > 0) begin
         m_pend--;
         if (m_pend == 0) begin e_valid = 1; e_i = r_i; e_q = r_q; end
      end
      pld  = cfg_we && !bz && (cfg_addr == 8'h19);
      wrap = in_valid && !pld && (m_cnt == m_dec);
      if (cfg_we && !bz) begin
         case (cfg_addr)
            8'h18: m_dec  = int'(cfg_wdata) & 7;
            8'h1A: m_taps = (cfg_wdata > 47) ? 48 : int'(cfg_wdata) + 1;
            8'h1B: m_n16  = cfg_wdata[0];
            default: ;
         endcase
      end
      if (coef_we && !bz && coef_addr < 48) m_c[coef_addr] = longint'($signed(coef_wdata));
      if (in_valid) begin
         for (int k = 47; k > 0; k--) begin
            m_h_i[k] = m_h_i[k-1];
            m_h_q[k] = m_h_q[k-1];
         end
         m_h_i[0] = longint'($signed(in_i));
         m_h_q[0] = longint'($signed(in_q));
      end
      if (pld)           m_cnt = int'(cfg_wdata) & 7;
      else if (in_valid) m_cnt = wrap ? 0 : (m_cnt + 1) & 7;
      if (wrap && bz) e_ovf = 1;
      if (wrap && !bz) begin
         ai = 0; aq = 0;
         for (int k = 0; k < m_taps; k++) begin
            ai += m_c[k] * m_h_i[k];
            aq += m_c[k] * m_h_q[k];
         end
         r_i = rsat(ai, m_n16);
         r_q = rsat(aq, m_n16);
         m_pend = m_taps + 1;
      end
   endtask

   task automatic tick();
      model_step();
      @(posedge clk);
      #1;
      chk("out_valid", longint'(out_valid), longint'(e_valid));
      chk("overflow", longint'(overflow), longint'(e_ovf));
      if (e_valid) begin
         chk("out_i", longint'($signed(out_i)), e_i);
         chk("out_q", longint'($signed(out_q)), e_q);
      end
      @(negedge clk);
   endtask

   task automatic wcfg(logic [7:0] a, logic [7:0] d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      tick();
      cfg_we = 1'b0;
   endtask

   task automatic wcoef(int a, longint c);
      coef_we = 1'b1; coef_addr = 6'(a); coef_wdata = 20'(c);
      tick();
      coef_we = 1'b0;
   endtask

   task automatic push(longint i, longint q, int gap);
      in_valid = 1'b1; in_i = 23'(i); in_q = 23'(q);
      tick();
      in_valid = 1'b0;
      repeat (gap) tick();
   endtask

   task automatic settle();
      repeat (60) tick();
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         n_err++;
         $display("FAIL watchdog (all requirements): actual %0d cycles expected below 150000", wd);
         finish_run();
      end
   end

   initial begin
      rst_n = 1'b0; cfg_we = 0; coef_we = 0; in_valid = 0;
      cfg_addr = 0; cfg_wdata = 0; coef_addr = 0; coef_wdata = 0; in_i = 0; in_q = 0;
      model_reset();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      cur_req = "R1";
      chk("reset out_valid", longint'(out_valid), 0);
      chk("reset overflow", longint'(overflow), 0);
      chk("reset out_i", longint'($signed(out_i)), 0);
      chk("reset out_q", longint'($signed(out_q)), 0);
      push(1000, -1000, 4);
      push(2000, 3000, 4);

      // R2: impulse then random data, four taps, shared coefficients
      cur_req = "R2";
      wcfg(8'h1A, 8'd3);
      wcoef(0, 262144); wcoef(1, -131072); wcoef(2, 65536); wcoef(3, 300000);
      push(100000, -50000, 6);
      for (int n = 0; n < 5; n++) push(0, 0, 6);
      for (int n = 0; n < 10; n++) push(rs23(), rs23(), 6);

      // R3: tap count clipped to 48 and exact output latency
      cur_req = "R3";
      settle();
      wcfg(8'h1A, 8'hFF);
      for (int k = 0; k < 48; k++) wcoef(k, rc20());
      for (int n = 0; n < 4; n++) push(rs23(), rs23(), 52);
      wcfg(8'h1A, 8'd8);
      for (int n = 0; n < 4; n++) push(rs23(), rs23(), 11);

      // R4: decimation by four, continuous input
      cur_req = "R4";
      settle();
      wcfg(8'h1A, 8'd2);
      wcfg(8'h18, 8'd3);
      for (int n = 0; n < 24; n++) push(rs23(), rs23(), 0);

      // R5: counter preload, inside and above the wrap value
      cur_req = "R5";
      settle();
      wcfg(8'h19, 8'd2);
      for (int n = 0; n < 16; n++) push(rs23(), rs23(), 0);
      settle();
      wcfg(8'h19, 8'd6);
      for (int n = 0; n < 16; n++) push(rs23(), rs23(), 0);

      // R6: 24-bit rounding and saturation at both ends
      cur_req = "R6";
      settle();
      wcfg(8'h1A, 8'd47);
      wcfg(8'h18, 8'd7);
      for (int k = 0; k < 48; k++) wcoef(k, 524287);
      for (int n = 0; n < 56; n++) push(4194303, -4194304, 7);
      for (int k = 0; k < 48; k++) wcoef(k, rc20() >>> 6);
      for (int n = 0; n < 40; n++) push(rs23(), rs23(), 7);

      // R10: cancelling full-scale partial sums
      cur_req = "R10";
      settle();
      for (int k = 0; k < 48; k++) wcoef(k, (k < 24) ? 524287 : -524288);
      for (int n = 0; n < 64; n++) push(4194303, (n % 2 == 0) ? 4194303 : -4194304, 7);

      // R7: 16-bit output format
      cur_req = "R7";
      settle();
      wcfg(8'h1B, 8'd1);
      for (int n = 0; n < 24; n++) push(4194303, -4194304, 7);
      for (int k = 0; k < 48; k++) wcoef(k, rc20());
      for (int n = 0; n < 40; n++) push(rs23(), rs23(), 7);

      // R8: triggers faster than the sequence length
      cur_req = "R8";
      settle();
      wcfg(8'h1B, 8'd0);
      wcfg(8'h1A, 8'd7);
      wcfg(8'h18, 8'd0);
      for (int n = 0; n < 30; n++) push(rs23(), rs23(), 0);

      // R9: writes during a running sequence are dropped
      cur_req = "R9";
      settle();
      push(rs23(), rs23(), 0);
      wcoef(0, 12345);
      wcfg(8'h1A, 8'd2);
      wcfg(8'h18, 8'd5);
      wcfg(8'h1B, 8'd1);
      wcoef(60, 777);
      settle();
      for (int n = 0; n < 6; n++) push(rs23(), rs23(), 10);
      wcoef(50, 999);
      for (int n = 0; n < 4; n++) push(rs23(), rs23(), 10);
      settle();
      finish_run();
   end
endmodule